// File: doc/BRIEF.md
# Coordinate-Targeted Raster Interrupt Generator

This block raises a CPU interrupt at a programmed screen position. It follows the beam with a dot counter and a line counter. Both advance on a pixel tick from the video timing reference. The CPU writes a vertical target byte and a horizontal target byte. The horizontal byte holds the pixel column divided by two. Halving the column costs nothing in practice, because the interrupt path already has about three pixels of jitter.

The interrupt is raised on purpose `LEAD_CYC` CPU cycles before the target pixel, at `PX_PER_CYC` pixel ticks per CPU cycle. The interrupt handler must then consume the leftover lead exactly. To do that, it reads a slop count that has been running since the interrupt fired. The count is the number of pixel ticks since the fire event, expressed in whole CPU cycles. The handler subtracts this from `LEAD_CYC` and burns the difference in a cycle-counted code path. The interrupt output stays high until software clears it.

The register port is a plain write strobe with an address and a byte. Each write takes effect on the clock edge where the strobe is sampled high, and the port has no back-pressure. The interrupt and slop outputs are plain status pins.

Top module: `raster_irq`

## Requirements
- R1: After reset, irq is 0, slop_cyc is 0 and the generator is disabled. The beam is at line 0, dot 0. Both target bytes read as 0, so enabling with no other write aims at vertical byte 0, horizontal byte 0.
- R2: On each clock with px_tick high, the dot counter advances by one. It wraps from LINE_PX-1 to 0, and on that wrap the line counter advances, wrapping from LINES-1 to 0. Nothing moves while px_tick is low, so the same fire point recurs every LINE_PX*LINES ticks.
- R3: Vertical byte v selects line (v + VBL_LINE + VBL_SKIP) mod LINES. With the defaults, v=255 is line VBL_LINE-1, the last line before vertical blank, and v=0 is line VBL_LINE+VBL_SKIP. Lines VBL_LINE through VBL_LINE+VBL_SKIP-1 are never a target.
- R4: Horizontal byte h selects dot 2*h. If 2*h >= LINE_PX, the target is off the line and the interrupt never fires.
- R5: The fire point is LEAD_CYC*PX_PER_CYC ticks before the target, and it wraps into the previous line or the previous frame when needed. irq rises on the clock after a px_tick cycle in which the beam sits at the fire point, provided that the block is enabled and irq is low.
- R6: Once high, irq stays high until a write to address 3 (acknowledge, any data), a write to address 0 or 1 (target rewrite), or a write to address 2 with bit 0 low. Any of these writes also blocks a fire in the same cycle.
- R7: slop_cyc is 0 on the clock where irq rises. It then equals floor(ticks since that fire / PX_PER_CYC) and saturates at 2^SLOP_W-1. An acknowledge does not reset it. From reset it counts in the same way.
- R8: While bit 0 of the control register is 0, irq never rises.
- R9: Register addresses are as follows: 0 is the vertical byte, 1 is the horizontal half-resolution byte, 2 is control (bit 0 is enable), and 3 is the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| px_tick | input | 1 | One pixel of beam advance in this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| irq | output | 1 | Interrupt request, held until cleared |
| slop_cyc | output | SLOP_W | CPU cycles elapsed since the last fire |

## Verification
A wrong beam counter or a wrong fire-point subtraction shows up as irq rising at the wrong pixel. The error appears at the first fire after the fault. It then repeats one frame later, which the frame-period check catches. A slop divider that drifts shows a wrong slop_cyc within three ticks of the fire, and a saturation fault shows within a few hundred ticks. A clear path that fails leaves irq high past the acknowledge write, which is visible on the very next clock.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
  typedef enum logic [1:0] {
    RSEL_VLINE = 2'd0,
    RSEL_HHALF = 2'd1,
    RSEL_CTRL  = 2'd2,
    RSEL_ACK   = 2'd3
  } rsel_e;
endpackage

// File: rtl/raster_irq_beam.sv
module raster_irq_beam #(
  parameter int LINE_PX = 341,
  parameter int LINES   = 262,
  parameter int DOT_W   = 9,
  parameter int LINE_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line
);
  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(LINE_PX - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot  <= '0;
      line <= '0;
    end else if (adv) begin
      if (dot == DOT_LAST) begin
        dot  <= '0;
        line <= (line == LINE_LAST) ? '0 : line + LINE_W'(1);
      end else begin
        dot <= dot + DOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/raster_irq_regs.sv
module raster_irq_regs
  import raster_irq_pkg::*;
#(
  parameter int LINE_PX  = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  parameter int VBL_SKIP = 6,
  parameter int LEAD_PX  = 42,
  parameter int DOT_W    = 9,
  parameter int LINE_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  rsel_e             wr_sel,
  input  logic [7:0]        wr_data,
  output logic              en,
  output logic [LINE_W-1:0] tgt_line,
  output logic [LINE_W-1:0] fire_line,
  output logic [DOT_W-1:0]  fire_dot,
  output logic              fire_ok,
  output logic              clr
);
  localparam int SUM_W = $clog2(256 + LINES);
  localparam int OFF   = (VBL_LINE + VBL_SKIP) % LINES;

  function automatic logic [LINE_W-1:0] map_line(input logic [7:0] v);
    logic [SUM_W-1:0] s;
    s = SUM_W'(v) + SUM_W'(OFF);
    return LINE_W'(s % SUM_W'(LINES));
  endfunction

  logic [LINE_W-1:0] tline_q;
  logic [8:0]        hd_q;
  logic              en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tline_q <= map_line(8'd0);
      hd_q    <= '0;
      en_q    <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_sel)
        RSEL_VLINE: tline_q <= map_line(wr_data);
        RSEL_HHALF: hd_q    <= {wr_data, 1'b0};
        RSEL_CTRL:  en_q    <= wr_data[0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    int hd;
    int fd;
    hd = 32'(hd_q);
    if (hd >= LEAD_PX) begin
      fd        = hd - LEAD_PX;
      fire_line = tline_q;
    end else begin
      fd        = hd + LINE_PX - LEAD_PX;
      fire_line = (tline_q == '0) ? LINE_W'(LINES - 1) : tline_q - LINE_W'(1);
    end
    fire_dot = DOT_W'(fd);
    fire_ok  = (hd < LINE_PX);
  end

  assign clr = wr_en && ((wr_sel != RSEL_CTRL) || !wr_data[0]);
  assign en       = en_q;
  assign tgt_line = tline_q;
endmodule

// File: rtl/raster_irq_slop.sv
module raster_irq_slop #(
  parameter int PX_PER_CYC = 3,
  parameter int CYC_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             restart,
  output logic [CYC_W-1:0] cyc
);
  logic [CYC_W-1:0] cyc_q;
  logic             cyc_step;

  generate
    if (PX_PER_CYC > 1) begin : g_div
      localparam int PH_W = $clog2(PX_PER_CYC);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(PX_PER_CYC - 1);
      logic [PH_W-1:0] ph_q;
      always_ff @(posedge clk) begin
        if (!rst_n || restart) ph_q <= '0;
        else if (adv)          ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
      end
      assign cyc_step = adv && (ph_q == PH_LAST);
    end else begin : g_direct
      assign cyc_step = adv;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || restart)          cyc_q <= '0;
    else if (cyc_step && cyc_q != '1) cyc_q <= cyc_q + CYC_W'(1);
  end

  assign cyc = cyc_q;
endmodule

// File: rtl/raster_irq.sv
module raster_irq
  import raster_irq_pkg::*;
#(
  parameter int LINE_PX    = 341,
  parameter int LINES      = 262,
  parameter int VBL_LINE   = 241,
  parameter int VBL_SKIP   = 6,
  parameter int LEAD_CYC   = 14,
  parameter int PX_PER_CYC = 3,
  parameter int SLOP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              px_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic              irq,
  output logic [SLOP_W-1:0] slop_cyc
);
  localparam int DOT_W   = $clog2(LINE_PX);
  localparam int LINE_W  = $clog2(LINES);
  localparam int LEAD_PX = LEAD_CYC * PX_PER_CYC;

  logic [DOT_W-1:0]  dot_w, fire_dot_w;
  logic [LINE_W-1:0] line_w, fire_line_w, tgt_line_w;
  logic              en_w, fire_ok_w, clr_w, at_fire, fire_ev, irq_q;

  raster_irq_beam #(
    .LINE_PX(LINE_PX), .LINES(LINES), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_beam (
    .clk(clk), .rst_n(rst_n), .adv(px_tick), .dot(dot_w), .line(line_w)
  );

  raster_irq_regs #(
    .LINE_PX(LINE_PX), .LINES(LINES), .VBL_LINE(VBL_LINE), .VBL_SKIP(VBL_SKIP),
    .LEAD_PX(LEAD_PX), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(rsel_e'(wr_addr)),
    .wr_data(wr_data), .en(en_w), .tgt_line(tgt_line_w),
    .fire_line(fire_line_w), .fire_dot(fire_dot_w), .fire_ok(fire_ok_w),
    .clr(clr_w)
  );

  assign at_fire = (dot_w == fire_dot_w) && (line_w == fire_line_w);
  assign fire_ev = px_tick && at_fire && en_w && fire_ok_w && !irq_q && !clr_w;

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (clr_w)   irq_q <= 1'b0;
    else if (fire_ev) irq_q <= 1'b1;
  end

  raster_irq_slop #(
    .PX_PER_CYC(PX_PER_CYC), .CYC_W(SLOP_W)
  ) u_slop (
    .clk(clk), .rst_n(rst_n), .adv(px_tick), .restart(fire_ev), .cyc(slop_cyc)
  );

  assign irq = irq_q;
endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk #(
  parameter int LINE_PX  = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  parameter int VBL_SKIP = 6,
  parameter int SLOP_W   = 8,
  parameter int DOT_W    = 9,
  parameter int LINE_W   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              px_tick,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic              irq,
  input logic [SLOP_W-1:0] slop,
  input logic              en,
  input logic [DOT_W-1:0]  dot,
  input logic [LINE_W-1:0] line,
  input logic [LINE_W-1:0] tgt_line
);
  AST_BEAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(dot) < LINE_PX) && (32'(line) < LINES)); // R2
  AST_BEAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !px_tick |=> $stable(dot) && $stable(line)); // R2
  AST_SKIP_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !((32'(tgt_line) >= VBL_LINE) && (32'(tgt_line) < VBL_LINE + VBL_SKIP))); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 2'd2) |=> !irq); // R6
  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en)); // R8
  AST_SLOP_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (slop == '0)); // R7
  AST_SLOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(irq) |-> (slop == $past(slop)) || (slop == $past(slop) + SLOP_W'(1))); // R7
endmodule

bind raster_irq raster_irq_chk #(
  .LINE_PX(LINE_PX), .LINES(LINES), .VBL_LINE(VBL_LINE), .VBL_SKIP(VBL_SKIP),
  .SLOP_W(SLOP_W), .DOT_W(DOT_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .px_tick(px_tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .irq(irq), .slop(slop_cyc), .en(en_w), .dot(dot_w), .line(line_w),
  .tgt_line(tgt_line_w)
);

// File: tb/sim_raster_irq.sv
`timescale 1ns/1ps
module sim_raster_irq;
  localparam int LPX = 44, LNS = 262, VBL = 241, SKIP = 6, LEAD = 14, PPC = 3;
  localparam int FRAME = LPX * LNS;
  localparam int LEADPX = LEAD * PPC;

  logic clk = 0, rst_n = 0, px_tick = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic irq;
  logic [7:0] slop;

  raster_irq #(.LINE_PX(LPX), .LINES(LNS), .VBL_LINE(VBL), .VBL_SKIP(SKIP),
               .LEAD_CYC(LEAD), .PX_PER_CYC(PPC), .SLOP_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .px_tick(px_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq), .slop_cyc(slop));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, tcount = 0;
  bit mon_on = 0;
  int mp, mpx, my, mh;
  bit mirq, men;

  function automatic int fire_index(int v, int h);
    int tl = (v + VBL + SKIP) % LNS;
    return (tl * LPX + 2 * h - LEADPX + FRAME) % FRAME;
  endfunction
  function automatic bit h_ok(int h);
    return (2 * h) < LPX;
  endfunction
  function automatic int exp_slop(int px);
    return (px / PPC > 255) ? 255 : px / PPC;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model of the requirements, updated at the same edge as the design
  always @(posedge clk) begin
    bit clr, fire;
    if (!rst_n) begin
      mp <= 0; mpx <= 0; my <= 0; mh <= 0; mirq <= 0; men <= 0;
    end else begin
      clr  = wr_en && (wr_addr != 2'd2 || !wr_data[0]);
      fire = px_tick && men && h_ok(mh) && (mp == fire_index(my, mh)) && !mirq && !clr;
      mirq <= clr ? 1'b0 : (fire ? 1'b1 : mirq);
      if (fire) mpx <= 0; else if (px_tick) mpx <= mpx + 1;
      if (px_tick) begin mp <= (mp + 1) % FRAME; tcount <= tcount + 1; end
      if (wr_en) case (wr_addr)
        2'd0: my <= wr_data;
        2'd1: mh <= wr_data;
        2'd2: men <= wr_data[0];
        default: ;
      endcase
    end
  end

  always @(negedge clk) px_tick <= ($urandom % 8) != 0;

  always @(negedge clk) if (rst_n && mon_on) begin
    chk(irq === mirq, "R5 irq vs counted reference", irq, mirq);
    chk(slop == exp_slop(mpx), "R7 slop vs counted reference", slop, exp_slop(mpx));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask
  task automatic wait_irq();
    int n = 0;
    while (irq !== 1'b1 && n < 30000) begin @(negedge clk); n++; end
  endtask
  task automatic wait_ticks(input int n);
    int t0 = tcount;
    while (tcount < t0 + n) @(negedge clk);
  endtask
  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R5 run hung actual=%0d expected=%0d", 1, 0);
    report(); $finish;
  end

  initial begin
    int v, h, t1;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk(irq == 0, "R1 irq low in reset", irq, 0);
    chk(slop == 0, "R1 slop zero in reset", slop, 0);
    rst_n = 1; mon_on = 1;

    // R1 default target, R5 fire point, R7 slop, R6/R9 acknowledge
    wr(2, 1);
    wait_irq();
    chk(irq == 1 && mp == (fire_index(0, 0) + 1) % FRAME, "R1 R5 default target fire pos", mp, (fire_index(0, 0) + 1) % FRAME);
    wait_ticks(30);
    chk(slop == 10, "R7 slop after 30 ticks", slop, 10);
    wr(3, 0);
    chk(irq == 0, "R6 R9 acknowledge clears", irq, 0);

    for (int i = 0; i < 3; i++) begin
      v = $urandom % 256; h = $urandom % 22;
      wr(2, 0); wr(0, v); wr(1, h); wr(2, 1);
      wait_irq();
      chk(irq == 1 && mp == (fire_index(v, h) + 1) % FRAME, "R5 random target fire pos", mp, (fire_index(v, h) + 1) % FRAME);
      wr(3, 0);
    end

    // R3 byte 255 is the line before blanking; dot 8 less the lead wraps a line back
    wr(2, 0); wr(0, 255); wr(1, 4); wr(2, 1);
    wait_irq();
    chk(mp == (VBL - 1) * LPX + 8 - LEADPX + 1, "R3 255 maps to last line before blank", mp, (VBL - 1) * LPX + 8 - LEADPX + 1);
    wr(3, 0);
    // R3 byte 0 is the first line after the skipped blank lines; 2*21 equals the lead
    wr(2, 0); wr(0, 0); wr(1, 21); wr(2, 1);
    wait_irq();
    chk(mp == (VBL + SKIP) * LPX + 1, "R3 byte 0 maps past skipped lines", mp, (VBL + SKIP) * LPX + 1);
    wr(3, 0);

    // R4 off-line horizontal target
    wr(2, 0); wr(0, 100); wr(1, 22); wr(2, 1);
    wait_ticks(FRAME + 50);
    chk(irq == 0, "R4 off-line target never fires", irq, 0);

    // R8 disabled
    wr(2, 0); wr(1, 5);
    wait_ticks(FRAME + 50);
    chk(irq == 0, "R8 disabled never fires", irq, 0);

    // R2 frame period, R7 saturation, R6 rewrite clears
    wr(2, 1);
    wait_irq();
    t1 = tcount;
    wait_ticks(800);
    chk(slop == 255, "R7 slop saturates", slop, 255);
    wr(3, 0);
    chk(slop == 255, "R7 acknowledge keeps slop", slop, 255);
    wait_irq();
    chk(tcount - t1 == FRAME, "R2 fire period equals frame", tcount - t1, FRAME);
    wr(0, 100);
    chk(irq == 0, "R6 target rewrite clears", irq, 0);

    repeat (4) @(negedge clk);
    report();
    $finish;
  end
endmodule